// File: doc/BRIEF.md
# HDLC Bit-Stream Receive Deframer

This block pulls one 8-bit lane out of a time-division-multiplexed word on each sample strobe. It feeds the lane's bits, least significant first, into a frame recoverer. The recoverer hunts for line activity, then for an opening flag. It drops stuffed zeros, packs the data bits into bytes and runs a CRC-16 over them. Payload bytes leave on a simple byte port with a start marker. Each frame is closed by an end strobe that carries one cause flag: good, checksum error, not byte aligned, too long, or aborted.

The block has two line modes. In 64 kbit/s mode it uses all eight lane bits. In 56 kbit/s mode it uses the low seven bits and ignores bit 7. The block shifts one bit per clock, so a new sample is taken only while `in_ready` is high. A sample whose used bits are all ones is treated as idle line: it throws the receiver back into the activity hunt without shifting any bits. The last two bytes of a frame are its check sequence and are never delivered, so bytes leave the block two bytes behind the line.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, `out_valid`, `out_start`, `out_end` and every cause flag are low and `in_ready` is high. The receiver waits for a 0 bit before it starts looking for a flag.
- R2: An opening flag counts only after a 0 bit has been seen while hunting. A run of six ones followed by a zero that arrives straight out of idle ones, with no such 0 before it, opens no frame, so no byte and no end strobe follow.
- R3: A 0 bit that comes after exactly five 1 bits is discarded and is not a data bit.
- R4: The flag pattern is 0x7E. The CRC is polynomial 0x8408, reflected, preset to 0xFFFF, taken over every received byte including the two check bytes. At a byte-aligned closing flag, a residual of 0xF0B8 gives an `out_end` pulse with `end_good`. The payload bytes are delivered in order, without the two check bytes, one per `out_valid` pulse, and `out_start` marks the first of them.
- R5: A byte-aligned closing flag with any other residual gives `out_end` with `end_fcs_err`. The cause flags are high only together with `out_end`.
- R6: A closing flag that arrives when the data bit count of the frame is not a multiple of 8 gives `out_end` with `end_align_err`.
- R7: When a byte completes in a frame that already holds MAX_BYTES bytes (check bytes included), the block gives `out_end` with `end_oversize`. It then ignores the rest of that frame until the next flag.
- R8: Seven consecutive 1 bits inside an open frame give `out_end` with `end_abort`. The receiver then returns to the activity hunt.
- R9: An accepted sample whose used bits are all ones returns the receiver to the activity hunt. If a frame was open, it gives `out_end` with `end_abort`.
- R10: A single flag can close one frame and open the next. Both frames are reported.
- R11: `mode56`=0 uses lane bits 7..0. `mode56`=1 uses lane bits 6..0 and ignores bit 7 for data and for the all-ones test. Bits are taken LSB first.
- R12: `lane_sel` picks which 8-bit lane of `tdm_word` is used. Lane n is bits 8n+7..8n. The other lanes have no effect.
- R13: An accepted sample that is not all ones drops `in_ready`. `in_ready` stays low for 8 clock edges in 64k mode and 7 in 56k mode. A sample strobe with `in_ready` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Sample strobe |
| tdm_word | input | LANES*8 | Multiplexed sample word |
| lane_sel | input | LSEL_W | Lane index |
| mode56 | input | 1 | 1 = 56k (7 bits), 0 = 64k (8 bits) |
| in_ready | output | 1 | Block can take a sample |
| out_valid | output | 1 | Payload byte strobe |
| out_data | output | 8 | Payload byte |
| out_start | output | 1 | First payload byte of a frame |
| out_end | output | 1 | Frame closed; one cause flag is high |
| end_good | output | 1 | Checksum correct |
| end_fcs_err | output | 1 | Checksum wrong |
| end_align_err | output | 1 | Frame not byte aligned |
| end_oversize | output | 1 | Frame too long |
| end_abort | output | 1 | Frame aborted by ones |

## Verification
The bench sends frames full of 0xFF and 0x7E bytes. A design that miscounted stuffed zeros would shift every later byte and fail the checksum. Frames of exactly MAX_BYTES and MAX_BYTES+1 bytes probe the length limit for an off-by-one. A zero-payload frame shows that only the check bytes are held back. A frame closed by a flag it shares with the next frame catches a design that drops back to the hunt after each frame. In 56k mode bit 7 is driven high, and the unused lane carries noise. A 0x7F sample in 56k mode must abort the open frame, which catches a design that applies the idle test to the wrong bit set.

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int LANES = 2,
  parameter int MAX_BYTES = 64,
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int NB_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic [LANES*8-1:0]   tdm_word,
  input  logic [LSEL_W-1:0]    lane_sel,
  input  logic                 mode56,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_start,
  output logic                 out_end,
  output logic                 end_good,
  output logic                 end_fcs_err,
  output logic                 end_align_err,
  output logic                 end_oversize,
  output logic                 end_abort
);

  localparam logic [15:0] RESIDUE = 16'hF0B8;

  typedef enum logic [1:0] {S_HUNT0, S_HUNTF, S_OPEN, S_FRAME} rx_st_t;

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  rx_st_t      st, n_st;
  logic [2:0]  ones, n_ones;
  logic [7:0]  acc, n_acc;
  logic [2:0]  pos, n_pos;
  logic [NB_W-1:0] nb, n_nb;
  logic [15:0] crc, n_crc;
  logic [7:0]  shreg;
  logic [3:0]  nleft;
  logic [7:0]  h0, h1;
  logic [1:0]  hcnt;
  logic        started;

  logic [7:0] lane_byte;
  logic       all_ones, accept, bit_v, b, databit, push, first;
  logic       ev_good, ev_fcs, ev_align, ev_over, ev_abort;

  assign lane_byte = tdm_word[{lane_sel, 3'b000} +: 8];
  assign all_ones  = mode56 ? (&lane_byte[6:0]) : (&lane_byte);
  assign in_ready  = (nleft == 4'd0);
  assign accept    = sample_valid && in_ready;
  assign bit_v     = !in_ready;
  assign b         = shreg[0];

  always_comb begin
    n_st = st; n_ones = ones; n_acc = acc; n_pos = pos; n_nb = nb; n_crc = crc;
    databit = 1'b0; push = 1'b0; first = 1'b0;
    ev_good = 1'b0; ev_fcs = 1'b0; ev_align = 1'b0; ev_over = 1'b0; ev_abort = 1'b0;
    if (accept && all_ones) begin
      n_st = S_HUNT0;
      n_ones = 3'd0;
      ev_abort = (st == S_FRAME);
    end else if (bit_v) begin
      case (st)
        S_HUNT0: if (!b) begin
          n_st = S_HUNTF;
          n_ones = 3'd0;
        end
        S_HUNTF: begin
          if (b) begin
            if (ones == 3'd6) begin
              n_st = S_HUNT0;
              n_ones = 3'd0;
            end else n_ones = ones + 3'd1;
          end else begin
            if (ones == 3'd6) begin
              n_st = S_OPEN;
              n_pos = 3'd0;
            end
            n_ones = 3'd0;
          end
        end
        default: begin
          if (b) begin
            if (ones == 3'd6) begin
              n_st = S_HUNT0;
              n_ones = 3'd0;
              ev_abort = (st == S_FRAME);
            end else begin
              n_ones = ones + 3'd1;
              databit = 1'b1;
            end
          end else begin
            n_ones = 3'd0;
            if (ones == 3'd6) begin
              n_st = S_OPEN;
              n_pos = 3'd0;
              if (st == S_FRAME) begin
                if (pos != 3'd7) ev_align = 1'b1;
                else if (crc == RESIDUE) ev_good = 1'b1;
                else ev_fcs = 1'b1;
              end
            end else if (ones != 3'd5) begin
              databit = 1'b1;
            end
          end
        end
      endcase
      if (databit) begin
        n_acc = {b, acc[7:1]};
        if (pos == 3'd7) begin
          n_pos = 3'd0;
          if (st == S_OPEN) begin
            n_st = S_FRAME;
            n_crc = crc_upd(16'hFFFF, n_acc);
            n_nb = NB_W'(1);
            push = 1'b1;
            first = 1'b1;
          end else if (nb == NB_W'(MAX_BYTES)) begin
            n_st = S_HUNTF;
            ev_over = 1'b1;
          end else begin
            n_crc = crc_upd(crc, n_acc);
            n_nb = nb + 1'b1;
            push = 1'b1;
          end
        end else begin
          n_pos = pos + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_HUNT0; ones <= '0; acc <= '0; pos <= '0; nb <= '0; crc <= 16'hFFFF;
      shreg <= '0; nleft <= '0; h0 <= '0; h1 <= '0; hcnt <= '0; started <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_start <= 1'b0; out_end <= 1'b0;
      end_good <= 1'b0; end_fcs_err <= 1'b0; end_align_err <= 1'b0;
      end_oversize <= 1'b0; end_abort <= 1'b0;
    end else begin
      st <= n_st; ones <= n_ones; acc <= n_acc; pos <= n_pos; nb <= n_nb; crc <= n_crc;
      if (accept && !all_ones) begin
        shreg <= lane_byte;
        nleft <= mode56 ? 4'd7 : 4'd8;
      end else if (bit_v) begin
        shreg <= shreg >> 1;
        nleft <= nleft - 4'd1;
      end
      out_valid <= 1'b0;
      out_start <= 1'b0;
      if (push) begin
        if (first) begin
          h0 <= n_acc; hcnt <= 2'd1; started <= 1'b0;
        end else if (hcnt == 2'd1) begin
          h1 <= n_acc; hcnt <= 2'd2;
        end else begin
          out_valid <= 1'b1;
          out_data  <= h0;
          out_start <= !started;
          started   <= 1'b1;
          h0 <= h1;
          h1 <= n_acc;
        end
      end
      out_end       <= ev_good | ev_fcs | ev_align | ev_over | ev_abort;
      end_good      <= ev_good;
      end_fcs_err   <= ev_fcs;
      end_align_err <= ev_align;
      end_oversize  <= ev_over;
      end_abort     <= ev_abort;
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_start,
  input logic out_end,
  input logic end_good,
  input logic end_fcs_err,
  input logic end_align_err,
  input logic end_oversize,
  input logic end_abort
);
  logic [4:0] cause;
  assign cause = {end_good, end_fcs_err, end_align_err, end_oversize, end_abort};

  AST_END_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> $onehot(cause)); // R4
  AST_CAUSE_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != 5'd0) |-> out_end); // R5
  AST_START_IS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid); // R4
  AST_NO_BYTE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |-> !out_valid); // R10
  AST_BUSY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(sample_valid)); // R13
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_start(out_start), .out_end(out_end),
  .end_good(end_good), .end_fcs_err(end_fcs_err), .end_align_err(end_align_err),
  .end_oversize(end_oversize), .end_abort(end_abort)
);

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb;
  localparam int MAXB = 16;
  localparam logic [4:0] C_GOOD = 5'b10000, C_FCS = 5'b01000, C_ALIGN = 5'b00100,
                         C_OVER = 5'b00010, C_ABORT = 5'b00001;

  logic clk = 1'b0, rst_n = 1'b0, sample_valid = 1'b0, mode56 = 1'b0;
  logic [15:0] tdm_word = '0;
  logic [0:0] lane_sel = '0;
  logic in_ready, out_valid, out_start, out_end;
  logic [7:0] out_data;
  logic end_good, end_fcs_err, end_align_err, end_oversize, end_abort;

  always #2 clk = ~clk;

  hdlc_rx_deframer #(.LANES(2), .MAX_BYTES(MAXB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .tdm_word(tdm_word),
    .lane_sel(lane_sel), .mode56(mode56), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_start(out_start), .out_end(out_end), .end_good(end_good),
    .end_fcs_err(end_fcs_err), .end_align_err(end_align_err),
    .end_oversize(end_oversize), .end_abort(end_abort));

  // vector: len[23:16] pat[15:12] m56[11:8] lane[7:4] expect[3:0] (0 good, 1 oversize)
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {8'd5,  4'd0, 4'd0, 4'd0, 4'd0},
    {8'd3,  4'd1, 4'd0, 4'd1, 4'd0},
    {8'd0,  4'd0, 4'd0, 4'd0, 4'd0},
    {8'd6,  4'd2, 4'd1, 4'd0, 4'd0},
    {8'd4,  4'd1, 4'd1, 4'd1, 4'd0},
    {8'd14, 4'd0, 4'd0, 4'd0, 4'd0},
    {8'd15, 4'd0, 4'd0, 4'd0, 4'd1},
    {8'd1,  4'd2, 4'd1, 4'd1, 4'd0}
  };

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic sb [0:4095];
  int sn = 0, txones = 0;
  logic [7:0] expd [0:255];
  int en = 0;
  logic [7:0] cap [0:255];
  int capn = 0, capst = 0, endn = 0;
  logic [4:0] lastc = '0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid && capn < 256) begin cap[capn] = out_data; capn++; end
    if (out_start) capst++;
    if (out_end) begin
      endn++;
      lastc = {end_good, end_fcs_err, end_align_err, end_oversize, end_abort};
    end
  end

  function automatic logic [15:0] crc16(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] pay(input int pat, input int i);
    if (pat == 1) return 8'hFF;
    if (pat == 2) return (i % 3 == 0) ? 8'h7E : ((i % 3 == 1) ? 8'h3F : 8'hFC);
    return 8'(i * 29 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_bit(input logic v); sb[sn] = v; sn++; endtask
  task automatic put_flag();
    put_bit(0); for (int i = 0; i < 6; i++) put_bit(1); put_bit(0);
    txones = 0;
  endtask
  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      put_bit(v[i]);
      if (v[i]) txones++; else txones = 0;
      if (txones == 5) begin put_bit(0); txones = 0; end
    end
  endtask
  task automatic put_body(input int len, input int pat, input bit corrupt);
    logic [15:0] c = 16'hFFFF;
    logic [7:0] d;
    for (int i = 0; i < len; i++) begin
      d = pay(pat, i);
      c = crc16(c, d);
      expd[en] = d; en++;
      put_byte((corrupt && i == 0) ? (d ^ 8'h01) : d);
    end
    c = ~c;
    put_byte(c[7:0]);
    put_byte(c[15:8]);
  endtask
  task automatic put_idle(); for (int i = 0; i < 16; i++) put_bit(1); endtask

  task automatic send_sample(input bit m56, input int lane, input logic [7:0] v);
    while (!in_ready) @(negedge clk);
    mode56 = m56;
    lane_sel = 1'(lane);
    tdm_word = (lane == 1) ? {v, 8'h5A} : {8'hA5, v};
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic send(input bit m56, input int lane, input logic padv);
    int w;
    logic [7:0] v;
    w = m56 ? 7 : 8;
    for (int p = 0; p < sn; p += w) begin
      v = 8'hFF;
      for (int j = 0; j < w; j++) v[j] = (p + j < sn) ? sb[p + j] : padv;
      send_sample(m56, lane, v);
    end
    sn = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic clr(); capn = 0; capst = 0; endn = 0; lastc = '0; en = 0; endtask

  task automatic cmp_bytes(input string req, input int n);
    int bad = 0;
    chk(capn == n, req, "byte count", capn, n);
    for (int i = 0; i < n && i < capn; i++) if (cap[i] !== expd[i]) bad++;
    chk(bad == 0, req, "byte mismatches", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && out_end == 0 && out_start == 0, "R1", "strobes at reset", out_valid + out_end, 0);
    chk(in_ready == 1, "R1", "in_ready at reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({end_good, end_fcs_err, end_align_err, end_oversize, end_abort} == 0, "R1", "flags after reset", 0, 0);

    // table: R4 R3 R7 R11 R12
    for (int k = 0; k < NV; k++) begin
      int len, pat, lane, ex;
      bit m56;
      len = int'(VEC[k][23:16]); pat = int'(VEC[k][15:12]);
      m56 = VEC[k][8]; lane = int'(VEC[k][7:4]); ex = int'(VEC[k][3:0]);
      clr();
      put_idle(); put_flag(); put_body(len, pat, 0); put_flag(); put_idle();
      send(m56, lane, 1'b1);
      chk(endn == 1, "R4", "end count", endn, 1);
      if (ex == 0) begin
        chk(lastc == C_GOOD, "R4", "cause good", lastc, C_GOOD);
        cmp_bytes(m56 ? "R11" : (lane == 1 ? "R12" : "R3"), len);
        chk(capst == (len > 0 ? 1 : 0), "R4", "start count", capst, len > 0 ? 1 : 0);
      end else begin
        chk(lastc == C_OVER, "R7", "cause oversize", lastc, C_OVER);
      end
    end

    // R5 checksum error
    clr(); put_flag(); put_body(4, 0, 1); put_flag(); put_idle(); send(0, 0, 1'b1);
    chk(endn == 1 && lastc == C_FCS, "R5", "fcs cause", lastc, C_FCS);
    chk(capn == 4, "R5", "bytes of bad frame", capn, 4);

    // R6 misaligned
    clr(); put_flag(); put_body(3, 0, 0);
    put_bit(0); put_bit(0); put_bit(0);
    put_flag(); put_idle(); send(0, 0, 1'b1);
    chk(endn == 1 && lastc == C_ALIGN, "R6", "align cause", lastc, C_ALIGN);

    // R8 seven ones abort
    clr(); put_flag(); put_body(3, 0, 0);
    for (int i = 0; i < 8; i++) put_bit(1);
    put_idle(); send(0, 0, 1'b1);
    chk(endn == 1 && lastc == C_ABORT, "R8", "ones abort", lastc, C_ABORT);

    // R9 all-ones sample mid frame, then recovery
    clr(); put_flag(); put_body(4, 0, 0); send(0, 0, 1'b0);
    send_sample(0, 0, 8'hFF); repeat (12) @(negedge clk);
    chk(endn == 1 && lastc == C_ABORT, "R9", "idle sample abort", lastc, C_ABORT);
    clr(); put_flag(); put_body(2, 0, 0); put_flag(); put_idle(); send(0, 0, 1'b1);
    chk(endn == 1 && lastc == C_GOOD, "R9", "recovery frame", lastc, C_GOOD);

    // R11 56k idle test on 7 bits: 0x7F aborts
    clr(); put_flag(); put_body(4, 1, 0); send(1, 0, 1'b0);
    send_sample(1, 0, 8'h7F); repeat (12) @(negedge clk);
    chk(endn == 1 && lastc == C_ABORT, "R11", "56k 0x7F abort", lastc, C_ABORT);

    // R10 shared flag
    clr(); put_flag(); put_body(3, 0, 0); put_flag(); put_body(4, 2, 0); put_flag(); put_idle();
    send(0, 1, 1'b1);
    chk(endn == 2 && lastc == C_GOOD, "R10", "two ends", endn, 2);
    chk(capst == 2, "R10", "two starts", capst, 2);
    cmp_bytes("R10", 7);

    // R2 no leading zero: no frame
    clr(); put_idle();
    for (int i = 0; i < 6; i++) put_bit(1);
    put_bit(0); put_body(3, 0, 0); put_flag(); put_idle();
    send(0, 0, 1'b1);
    chk(endn == 0 && capn == 0, "R2", "no frame without hunt zero", endn + capn, 0);

    // R13 busy window
    send_sample(0, 0, 8'h00);
    repeat (7) @(negedge clk);
    chk(in_ready == 0, "R13", "busy after 7 edges 64k", in_ready, 0);
    @(negedge clk);
    chk(in_ready == 1, "R13", "ready after 8 edges 64k", in_ready, 1);
    send_sample(1, 0, 8'h00);
    repeat (6) @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1, "R13", "ready after 7 edges 56k", in_ready, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule